// File: doc/BRIEF.md
# Packet Send Flit Serializer

This block turns software register writes and memory reads into an outgoing stream of 9-bit network flits. Each flit carries 8 data bits and a tail bit, and the tail bit marks the last flit of a packet. Software can append a single byte, a half-word or a full word to the packet under construction. It can also close the packet with a tail flit that carries a CRC-8 check byte, or a zero byte when checking is turned off.

For bulk data, software loads a start pointer and then writes a limit address. A send-DMA engine then fetches word-aligned memory one word per request and serializes every word from the pointer up to and including the limit, most significant byte first. A variant of the limit write also closes the packet after the last word. A one-shot skip setting can drop up to three leading bytes of the next DMA buffer.

Two status flags govern software. Send-ready says a programmed append can be issued. Send-complete says the last DMA buffer has been fully appended. The flit output uses a valid/ready handshake and holds its flit while the receiver stalls.

Top module: `pktSendSerializer`

## Requirements
- R1: A write with `regSel`=0 while `sendRdy`=1 appends one flit, tail bit 0, whose data is `regWrData[7:0]`.
- R2: A write with `regSel`=1 while `sendRdy`=1 appends two data flits, `regWrData[15:8]` first and then `regWrData[7:0]`.
- R3: A write with `regSel`=2 while `sendRdy`=1 appends four data flits, `regWrData[31:24]` first and `regWrData[7:0]` last.
- R4: A write of 0 with `regSel`=3 while `sendRdy`=1 appends one flit with the tail bit set. When `crcEnable`=1 its data is the CRC-8 (polynomial 0x07, initial value 0, each byte processed MSB first) over every data flit sent since the previous tail flit. A nonzero value written with `regSel`=3 appends nothing.
- R5: When `crcEnable`=0, every tail flit carries data 0x00. The CRC still restarts after the tail.
- R6: A write with `regSel`=4 while idle starts a DMA. The DMA appends the memory words at `ptrOut`, `ptrOut`+4, …, up to and including the limit, each MSB first. It raises `memReq` for one cycle per word with `memAddr` = the word address, and takes `memRdata` on the following clock edge.
- R7: A write with `regSel`=5 acts like `regSel`=4 and also appends a CRC tail flit after the last word of the buffer.
- R8: A write with `regSel`=6 while idle loads the pointer. The pointer and the limit read back on `ptrOut` and `limitOut` with their two low bits forced to 0. When the DMA completes, `ptrOut` equals `limitOut`+4.
- R9: A write with `regSel`=7 arms a skip of `regWrData[1:0]` leading bytes (0 to 3). The skip applies to the first word of the next DMA started after the write, and to no later DMA.
- R10: `sendRdy` is 1 after reset. It is 0 from the clock edge that takes a limit write until the DMA completes and the flit holding stage drains. It is also 0 while any programmed flit is pending. Append writes (`regSel` 0 to 3) issued while `sendRdy`=0 are ignored.
- R11: `sendDone` is 0 after reset. It is set when the last DMA word is appended. It is cleared by a write with `regSel`=8 and `regWrData[0]`=1, or by a limit write (`regSel` 4 or 5). A `regSel`=8 write with bit 0 equal to 0 leaves it unchanged.
- R12: While `flitValid`=1 and `flitReady`=0, the flit on `flitData` and `flitTail` is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 4 | Register selector (0 byte, 1 half, 2 word, 3 tail, 4 limit, 5 limit with tail, 6 pointer, 7 skip, 8 status) |
| regWrData | input | 32 | Register write value |
| crcEnable | input | 1 | 1: tail flits carry CRC-8, 0: tail flits carry zero |
| flitValid | output | 1 | Output flit present |
| flitData | output | 8 | Output flit data byte |
| flitTail | output | 1 | Output flit is a tail flit |
| flitReady | input | 1 | Receiver accepts the flit this cycle |
| memReq | output | 1 | Memory read request, one word |
| memAddr | output | AddrW | Byte address of the requested word |
| memRdata | input | 32 | Read data, valid the cycle after memReq |
| ptrOut | output | AddrW | DMA pointer readback |
| limitOut | output | AddrW | DMA limit readback |
| sendRdy | output | 1 | Programmed appends may be issued |
| sendDone | output | 1 | Send-DMA completed |

## Verification
The hardest case to reach from the ports is a DMA whose first word is cut short by an armed skip while the receiver applies backpressure. In that case the fetch of the next word has to wait for the holding stage to drain, and the CRC tail has to fold in only the bytes that were actually sent. The bench sweeps every skip value against buffer lengths of one to four words, with and without the closing tail and with and without a periodic stall on `flitReady`. It predicts every flit and the final pointer arithmetically. Separate sequences stall the output completely to show that appends issued while not ready are dropped, and start back-to-back DMAs to show that the skip setting is consumed once.

// File: rtl/pktSendPkg.sv
package pktSendPkg;
  localparam int WordBytes = 4;
  localparam int ByteW     = 8;
  localparam int WordW     = WordBytes * ByteW;
  localparam int CntW      = $clog2(WordBytes + 1);
  localparam int SkipW     = $clog2(WordBytes);
  localparam int SelW      = 4;

  localparam logic [SelW-1:0] SelByte   = 4'd0;
  localparam logic [SelW-1:0] SelHalf   = 4'd1;
  localparam logic [SelW-1:0] SelWord   = 4'd2;
  localparam logic [SelW-1:0] SelTail   = 4'd3;
  localparam logic [SelW-1:0] SelLimit  = 4'd4;
  localparam logic [SelW-1:0] SelLimitT = 4'd5;
  localparam logic [SelW-1:0] SelPtr    = 4'd6;
  localparam logic [SelW-1:0] SelSkip   = 4'd7;
  localparam logic [SelW-1:0] SelStatus = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;      // load holding stage with a left-aligned word
    logic [WordW-1:0] loadWord;
    logic [CntW-1:0]  loadCnt;   // number of valid leading bytes
    logic             addTail;   // queue a tail flit behind the bytes
  } dpCmd_t;

  function automatic logic [ByteW-1:0] crcStep(input logic [ByteW-1:0] crc,
                                               input logic [ByteW-1:0] din,
                                               input logic [ByteW-1:0] poly);
    logic [ByteW-1:0] acc;
    acc = crc ^ din;
    for (int i = 0; i < ByteW; i++) begin
      acc = acc[ByteW-1] ? ((acc << 1) ^ poly) : (acc << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/pktSendDatapath.sv
module pktSendDatapath
  import pktSendPkg::*;
#(
  parameter logic [ByteW-1:0] CrcPoly = 8'h07
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           dpCmd,
  input  logic             crcEnable,
  input  logic             flitReady,
  output logic             flitValid,
  output logic [ByteW-1:0] flitData,
  output logic             flitTail,
  output logic             bufEmpty
);
  logic [WordW-1:0] byteBuf;
  logic [CntW-1:0]  byteCnt;
  logic             tailPend;
  logic [ByteW-1:0] crcReg;
  logic             haveData;
  logic             fire;
  logic             dataFire;
  logic             tailFire;

  always_comb begin
    haveData  = (byteCnt != '0);
    flitValid = haveData || tailPend;
    flitTail  = !haveData && tailPend;
    flitData  = haveData ? byteBuf[WordW-1 -: ByteW]
                         : (crcEnable ? crcReg : '0);
    bufEmpty  = !flitValid;
    fire      = flitValid && flitReady;
    dataFire  = fire && haveData;
    tailFire  = fire && !haveData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteBuf  <= '0;
      byteCnt  <= '0;
      tailPend <= 1'b0;
      crcReg   <= '0;
    end else begin
      if (dpCmd.load) begin
        byteBuf <= dpCmd.loadWord;
        byteCnt <= dpCmd.loadCnt;
      end else if (dataFire) begin
        byteBuf <= byteBuf << ByteW;
        byteCnt <= byteCnt - 1'b1;
      end

      if (dpCmd.addTail) begin
        tailPend <= 1'b1;
      end else if (tailFire) begin
        tailPend <= 1'b0;
      end

      if (dataFire) begin
        crcReg <= crcStep(crcReg, byteBuf[WordW-1 -: ByteW], CrcPoly);
      end else if (tailFire) begin
        crcReg <= '0;
      end
    end
  end
endmodule

// File: rtl/pktSendCtrl.sv
module pktSendCtrl
  import pktSendPkg::*;
#(
  parameter int AddrW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SelW-1:0]  regSel,
  input  logic [WordW-1:0] regWrData,
  input  logic [WordW-1:0] memRdata,
  input  logic             bufEmpty,
  output dpCmd_t           dpCmd,
  output logic             memReq,
  output logic [AddrW-1:0] memAddr,
  output logic [AddrW-1:0] ptrOut,
  output logic [AddrW-1:0] limitOut,
  output logic             sendRdy,
  output logic             sendDone,
  output logic             dmaBusy
);
  localparam logic [AddrW-1:0] WordStep  = AddrW'(WordBytes);
  localparam logic [AddrW-1:0] AlignMask = ~(WordStep - 1'b1);

  typedef enum logic [1:0] {StIdle, StFetch, StLand} state_e;

  state_e           state;
  logic [AddrW-1:0] ptrReg;
  logic [AddrW-1:0] limitReg;
  logic             withTail;
  logic             skipArm;
  logic [SkipW-1:0] skipVal;
  logic [SkipW-1:0] skipCur;
  logic             doneReg;
  logic             idle;
  logic             lastWord;
  logic             startDma;
  logic             clrDone;

  always_comb begin
    idle     = (state == StIdle);
    sendRdy  = idle && bufEmpty;
    dmaBusy  = !idle;
    memReq   = (state == StFetch) && bufEmpty;
    memAddr  = ptrReg;
    ptrOut   = ptrReg;
    limitOut = limitReg;
    sendDone = doneReg;
    lastWord = (ptrReg == limitReg);
    startDma = idle && regWrEn && ((regSel == SelLimit) || (regSel == SelLimitT));
    clrDone  = regWrEn && (regSel == SelStatus) && regWrData[0];

    dpCmd = '0;
    if (state == StLand) begin
      dpCmd.load     = 1'b1;
      dpCmd.loadWord = memRdata << {skipCur, 3'b000};
      dpCmd.loadCnt  = CntW'(WordBytes) - CntW'(skipCur);
      dpCmd.addTail  = lastWord && withTail;
    end else if (sendRdy && regWrEn) begin
      case (regSel)
        SelByte: begin
          dpCmd.load     = 1'b1;
          dpCmd.loadWord = {regWrData[ByteW-1:0], {(WordW-ByteW){1'b0}}};
          dpCmd.loadCnt  = CntW'(1);
        end
        SelHalf: begin
          dpCmd.load     = 1'b1;
          dpCmd.loadWord = {regWrData[2*ByteW-1:0], {(WordW-2*ByteW){1'b0}}};
          dpCmd.loadCnt  = CntW'(2);
        end
        SelWord: begin
          dpCmd.load     = 1'b1;
          dpCmd.loadWord = regWrData;
          dpCmd.loadCnt  = CntW'(WordBytes);
        end
        SelTail: begin
          dpCmd.addTail  = (regWrData == '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= StIdle;
      ptrReg   <= '0;
      limitReg <= '0;
      withTail <= 1'b0;
      skipArm  <= 1'b0;
      skipVal  <= '0;
      skipCur  <= '0;
      doneReg  <= 1'b0;
    end else begin
      case (state)
        StIdle: begin
          if (startDma) begin
            state    <= StFetch;
            limitReg <= regWrData[AddrW-1:0] & AlignMask;
            withTail <= (regSel == SelLimitT);
            skipCur  <= skipArm ? skipVal : '0;
            skipArm  <= 1'b0;
          end else if (regWrEn && (regSel == SelPtr)) begin
            ptrReg <= regWrData[AddrW-1:0] & AlignMask;
          end
        end
        StFetch: begin
          if (bufEmpty) state <= StLand;
        end
        StLand: begin
          ptrReg  <= ptrReg + WordStep;
          skipCur <= '0;
          state   <= lastWord ? StIdle : StFetch;
        end
        default: state <= StIdle;
      endcase

      if (regWrEn && (regSel == SelSkip)) begin
        skipVal <= regWrData[SkipW-1:0];
        skipArm <= 1'b1;
      end

      if ((state == StLand) && lastWord) begin
        doneReg <= 1'b1;
      end else if (startDma || clrDone) begin
        doneReg <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pktSendSerializer.sv
module pktSendSerializer
  import pktSendPkg::*;
#(
  parameter int               AddrW   = 32,
  parameter logic [ByteW-1:0] CrcPoly = 8'h07
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SelW-1:0]  regSel,
  input  logic [WordW-1:0] regWrData,
  input  logic             crcEnable,
  output logic             flitValid,
  output logic [ByteW-1:0] flitData,
  output logic             flitTail,
  input  logic             flitReady,
  output logic             memReq,
  output logic [AddrW-1:0] memAddr,
  input  logic [WordW-1:0] memRdata,
  output logic [AddrW-1:0] ptrOut,
  output logic [AddrW-1:0] limitOut,
  output logic             sendRdy,
  output logic             sendDone
);
  dpCmd_t dpCmd;
  logic   bufEmpty;
  logic   dmaBusy;

  pktSendCtrl #(.AddrW(AddrW)) ctrlInst (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memRdata(memRdata), .bufEmpty(bufEmpty), .dpCmd(dpCmd),
    .memReq(memReq), .memAddr(memAddr),
    .ptrOut(ptrOut), .limitOut(limitOut),
    .sendRdy(sendRdy), .sendDone(sendDone), .dmaBusy(dmaBusy)
  );

  pktSendDatapath #(.CrcPoly(CrcPoly)) dpInst (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .crcEnable(crcEnable),
    .flitReady(flitReady), .flitValid(flitValid), .flitData(flitData),
    .flitTail(flitTail), .bufEmpty(bufEmpty)
  );
endmodule

// File: rtl/pktSendChecker.sv
module pktSendChecker
  import pktSendPkg::*;
#(
  parameter int AddrW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [SelW-1:0]  regSel,
  input logic             flitValid,
  input logic [ByteW-1:0] flitData,
  input logic             flitTail,
  input logic             flitReady,
  input logic             memReq,
  input logic [AddrW-1:0] ptrOut,
  input logic [AddrW-1:0] limitOut,
  input logic             sendRdy,
  input logic             sendDone,
  input logic             dmaBusy
);
  // R12
  flit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flitValid && !flitReady |=> flitValid && $stable(flitData) && $stable(flitTail));

  // R10
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && sendRdy && ((regSel == SelLimit) || (regSel == SelLimitT)) |=> !sendRdy);

  // R10
  busy_not_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaBusy |-> !sendRdy && !sendDone || !sendRdy);

  // R10
  rdy_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendRdy |-> !flitValid);

  // R8
  ptr_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendDone) |-> ptrOut == limitOut + AddrW'(WordBytes));

  // R11
  done_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendDone) |-> $past(regWrEn));

  // R6
  mem_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
endmodule

bind pktSendSerializer pktSendChecker #(.AddrW(AddrW)) chkInst (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .flitValid(flitValid), .flitData(flitData), .flitTail(flitTail),
  .flitReady(flitReady), .memReq(memReq), .ptrOut(ptrOut),
  .limitOut(limitOut), .sendRdy(sendRdy), .sendDone(sendDone),
  .dmaBusy(dmaBusy)
);

// File: tb/pktSendSerializer_test.sv
module pktSendSerializer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic        crcEnable = 1'b1;
  logic        flitValid;
  logic [7:0]  flitData;
  logic        flitTail;
  logic        flitReady = 1'b1;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memRdata = '0;
  logic [31:0] ptrOut;
  logic [31:0] limitOut;
  logic        sendRdy;
  logic        sendDone;

  int checks = 0;
  int fails = 0;
  int bpMode = 0;
  int cyc = 0;
  logic [7:0] crcE = '0;
  logic [8:0] expQ[$];
  logic [8:0] gotQ[$];

  always #4 clk = ~clk;

  pktSendSerializer uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .crcEnable(crcEnable), .flitValid(flitValid),
    .flitData(flitData), .flitTail(flitTail), .flitReady(flitReady),
    .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata),
    .ptrOut(ptrOut), .limitOut(limitOut), .sendRdy(sendRdy), .sendDone(sendDone)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [7:0] k;
    k = a[9:2];
    return {k ^ 8'h5A, k + 8'd17, ~k, k * 8'd3};
  endfunction

  function automatic logic [7:0] crcNext(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  always @(posedge clk) memRdata <= memWord(memAddr);

  always @(posedge clk) begin
    if (rstN && flitValid && flitReady) gotQ.push_back({flitTail, flitData});
  end

  always @(negedge clk) begin
    cyc++;
    flitReady = (bpMode == 0) ? 1'b1 : (bpMode == 1) ? ((cyc % 3) != 0) : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] sel, input logic [31:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expByte(input logic [7:0] b);
    expQ.push_back({1'b0, b});
    crcE = crcNext(crcE, b);
  endtask

  task automatic expTail();
    expQ.push_back({1'b1, crcEnable ? crcE : 8'h00});
    crcE = '0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!sendRdy && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cmpStream(input string tag);
    chk(gotQ.size() == expQ.size(), {tag, " flit count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++) begin
      chk(gotQ[i] == expQ[i], tag, {23'd0, gotQ[i]}, {23'd0, expQ[i]});
    end
    gotQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=%0d exp=0", 1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: R10 R11
    chk(sendRdy == 1'b1, "R10 reset sendRdy", sendRdy, 1);
    chk(sendDone == 1'b0, "R11 reset sendDone", sendDone, 0);
    chk(flitValid == 1'b0, "R12 reset flitValid", flitValid, 0);
    chk(memReq == 1'b0, "R6 reset memReq", memReq, 0);
    chk(ptrOut == 32'd0, "R8 reset ptr", ptrOut, 0);

    // programmed appends: R1 R2 R3 R4 under both output patterns
    for (int v = 0; v < 16; v++) begin
      bpMode = v % 2;
      wrReg(4'd0, {8'hC3, 16'h0, 8'(v * 17 + 3)});
      expByte(8'(v * 17 + 3));
      waitIdle();
      wrReg(4'd1, {16'hFFFF, 8'(v * 9), 8'(~v)});
      expByte(8'(v * 9)); expByte(8'(~v));
      waitIdle();
      wrReg(4'd2, {8'(v), 8'hA0 | 8'(v), 8'(v << 4), 8'h3C});
      expByte(8'(v)); expByte(8'hA0 | 8'(v)); expByte(8'(v << 4)); expByte(8'h3C);
      waitIdle();
      if (v % 4 == 3) begin
        wrReg(4'd3, 32'd0);
        expTail();
        waitIdle();
      end
      cmpStream("R1 R2 R3 R4 programmed stream");
    end
    bpMode = 0;

    // R4: nonzero tail value appends nothing
    wrReg(4'd3, 32'd5);
    repeat (6) @(negedge clk);
    cmpStream("R4 nonzero tail ignored");

    // R5: zero tail when crc disabled
    crcEnable = 1'b0;
    wrReg(4'd2, 32'h1234_5678);
    expByte(8'h12); expByte(8'h34); expByte(8'h56); expByte(8'h78);
    waitIdle();
    wrReg(4'd3, 32'd0);
    expTail();
    waitIdle();
    cmpStream("R5 zero tail");
    crcEnable = 1'b1;

    // R10: append while not ready is dropped
    bpMode = 2;
    @(negedge clk);
    wrReg(4'd0, 32'h11);
    expByte(8'h11);
    chk(sendRdy == 1'b0, "R10 busy after append", sendRdy, 0);
    wrReg(4'd0, 32'h22);
    wrReg(4'd2, 32'hDEAD_BEEF);
    bpMode = 0;
    waitIdle();
    cmpStream("R10 append ignored while not ready");

    // DMA sweep: R6 R7 R8 R9 R10 R11 R12
    for (int skip = 0; skip < 4; skip++) begin
      for (int nw = 1; nw <= 4; nw++) begin
        for (int tl = 0; tl < 2; tl++) begin
          for (int bp = 0; bp < 2; bp++) begin
            logic [31:0] base;
            logic [31:0] lim;
            base = 32'h100 + 32'((skip * 8 + nw * 2 + tl) * 16);
            lim = base + 32'(4 * (nw - 1));
            bpMode = bp;
            wrReg(4'd6, base);
            chk(ptrOut == base, "R8 pointer readback", ptrOut, base);
            wrReg(4'd7, 32'(skip));
            for (int w = 0; w < nw; w++) begin
              logic [31:0] mw;
              mw = memWord(base + 32'(4 * w));
              for (int b = (w == 0) ? skip : 0; b < 4; b++) expByte(mw[31 - 8 * b -: 8]);
            end
            if (tl == 1) expTail();
            wrReg(tl ? 4'd5 : 4'd4, lim);
            chk(sendRdy == 1'b0, "R10 not ready during DMA", sendRdy, 0);
            chk(sendDone == 1'b0, "R11 limit write clears done", sendDone, 0);
            waitIdle();
            chk(sendDone == 1'b1, "R11 done after DMA", sendDone, 1);
            chk(limitOut == lim, "R8 limit readback", limitOut, lim);
            chk(ptrOut == lim + 32'd4, "R8 final pointer", ptrOut, lim + 32'd4);
            cmpStream(tl ? "R7 R9 DMA with tail" : "R6 R9 DMA stream");
            wrReg(4'd8, 32'd0);
            chk(sendDone == 1'b1, "R11 status write 0 no effect", sendDone, 1);
            wrReg(4'd8, 32'd1);
            chk(sendDone == 1'b0, "R11 status write 1 clears", sendDone, 0);
          end
        end
      end
    end
    bpMode = 0;

    // R9: skip applies to first DMA only
    wrReg(4'd6, 32'h40);
    wrReg(4'd7, 32'd3);
    begin
      logic [31:0] mw;
      mw = memWord(32'h40);
      expByte(mw[7:0]);
      wrReg(4'd4, 32'h40);
      waitIdle();
      cmpStream("R9 skip three on single word");
      wrReg(4'd6, 32'h80);
      mw = memWord(32'h80);
      expByte(mw[31:24]); expByte(mw[23:16]); expByte(mw[15:8]); expByte(mw[7:0]);
      wrReg(4'd4, 32'h80);
      waitIdle();
      cmpStream("R9 skip not reused");
    end

    // R8: low address bits forced to zero
    wrReg(4'd6, 32'h203);
    chk(ptrOut == 32'h200, "R8 pointer low bits", ptrOut, 32'h200);
    for (int w = 0; w < 2; w++) begin
      logic [31:0] mw;
      mw = memWord(32'h200 + 32'(4 * w));
      expByte(mw[31:24]); expByte(mw[23:16]); expByte(mw[15:8]); expByte(mw[7:0]);
    end
    expTail();
    wrReg(4'd5, 32'h207);
    chk(limitOut == 32'h204, "R8 limit low bits", limitOut, 32'h204);
    waitIdle();
    chk(ptrOut == 32'h208, "R8 pointer after masked DMA", ptrOut, 32'h208);
    cmpStream("R7 R8 masked DMA stream");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule